// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked front end for an external asynchronous static RAM that is 16 bits wide and has two independently strobed byte lanes. A client issues single read or write requests over a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data and two byte-enable bits. Read data comes back with a one-cycle valid pulse. On the memory side the block drives active-low chip-enable, write-enable, output-enable and two lane strobes. The bidirectional data bus is split into an output word, an input word and a drive enable, so that the pad ring can build the tri-state buffer.

The memory's nanosecond limits are parameters in picoseconds, together with the clock period. The block converts each limit into a whole number of clock cycles, rounding up, with at least one cycle per phase. A small sequencer then steps through an address phase, an access phase and a recovery phase. Output-enable stays high for the whole of every write. The controller starts driving the bus only one cycle after write-enable has fallen, so the memory and the controller never drive the bus at the same time. Each read is followed by one quiet cycle for bus turnaround.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1, `rsp_valid` is 0, every memory strobe (`mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n`, `mem_ub_n`) is 1 and `mem_dq_oe` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is low from that edge until the access is over, and requests presented while it is low have no effect. With the default parameters, `req_ready` returns 4 cycles after the accepting edge, for reads and for writes alike.
- R3: `mem_addr` changes only in a cycle where all strobes were high before the change and are still high after it. At least the address-setup count of cycles (1 at defaults) passes between an address change and the next strobe falling.
- R4: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the read count of cycles: the longest of address access, read cycle, output-enable access and lane access, divided by the clock period and rounded up (2 cycles at 5 ns). Lane strobes follow the enables: `req_be[0]` lowers `mem_lb_n` for bits 7:0 and `req_be[1]` lowers `mem_ub_n` for bits 15:8. `mem_dq_oe` stays 0.
- R5: `rsp_valid` is a single-cycle pulse that rises 3 cycles after the accepting edge of a read at defaults. `rsp_rdata` holds `mem_dq_in` as sampled at the end of the last read cycle, with the bits of any lane whose enable was 0 forced to zero.
- R6: A write holds `mem_oe_n`=1 throughout and keeps `mem_ce_n` and `mem_we_n` low for the write-pulse count of cycles. That count is the largest of the pulse width, the address-to-end-of-write time less the setup phase, and one cycle plus the data setup, each rounded up (2 cycles at defaults). The lane strobes follow the enables as in R4.
- R7: `mem_dq_oe` is 0 in the first write-enable-low cycle and 1 for the rest of the pulse and through the recovery cycle after write-enable rises. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: A lane whose enable bit is 0 is not written. A write with both enables at 0 leaves the stored word unchanged.
- R9: After the last read cycle, one turnaround cycle with every strobe high and `mem_dq_oe` at 0 comes before `req_ready` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
With a 5 ns clock, a read's `rsp_valid` is due 3 edges after the accepting edge, and `req_ready` is due back 4 edges after acceptance for both access types. The memory pins change on the accepting edge (address) and one edge later (strobes). The bench's behavioural model counts these latencies from the same acceptance edge the design sees, and it compares `req_ready`, `rsp_valid` and `rsp_rdata` at every falling edge, half a cycle after the outputs settle. A pin-level memory model in the bench also samples the strobes at falling edges. It measures pulse and drive windows in whole cycles, returns read data only once the read has been active for the access count, and commits a write only when write-enable rises.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and cycle-count helpers for the SRAM
// controller. Assumes all timing parameters are non-negative picoseconds.
package sram_ctl_pkg;

    localparam int LANES  = 2;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RD,
        ST_TURN,
        ST_WE,
        ST_WD,
        ST_WREC
    } ctl_state_e;

    // Round a time up to whole clock periods, never below one cycle.
    function automatic int cycles_for(input int ps, input int period_ps);
        int c;
        c = (ps + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two counts.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
// Sequencer: walks each access through address, access and recovery
// phases, each lasting a parameter number of cycles. Assumes every count
// is at least one.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int AS_CYC   = 1,
    parameter int RD_CYC   = 2,
    parameter int WD_CYC   = 1,
    parameter int REC_CYC  = 1,
    parameter int TURN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       idle,
    output ctl_state_e nxt_state,
    output logic       rd_last
);

    localparam logic [CNT_W-1:0] AS_LOAD   = CNT_W'(AS_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WD_LOAD   = CNT_W'(WD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] cnt_q, nxt_cnt;
    logic             wr_q, nxt_wr;
    logic             last;

    assign last    = (cnt_q == '0);
    assign idle    = (state_q == ST_IDLE);
    assign rd_last = (state_q == ST_RD) && last;

    // Next-state and phase-counter selection.
    always_comb begin
        nxt_state = state_q;
        nxt_wr    = wr_q;
        nxt_cnt   = last ? cnt_q : cnt_q - 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_state = ST_ADDR;
                    nxt_cnt   = AS_LOAD;
                    nxt_wr    = req_write;
                end
            end
            ST_ADDR: begin
                if (last) begin
                    if (wr_q) begin
                        nxt_state = ST_WE;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_state = ST_RD;
                        nxt_cnt   = RD_LOAD;
                    end
                end
            end
            ST_RD: begin
                if (last) begin
                    nxt_state = ST_TURN;
                    nxt_cnt   = TURN_LOAD;
                end
            end
            ST_TURN: begin
                if (last) nxt_state = ST_IDLE;
            end
            ST_WE: begin
                nxt_state = ST_WD;
                nxt_cnt   = WD_LOAD;
            end
            ST_WD: begin
                if (last) begin
                    nxt_state = ST_WREC;
                    nxt_cnt   = REC_LOAD;
                end
            end
            ST_WREC: begin
                if (last) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State, counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
            wr_q    <= nxt_wr;
        end
    end

endmodule

// File: rtl/sram_ctl_pins.sv
// Pin driver: registers every memory-side output from the sequencer's
// next state, so pins switch on the same edge as the state and never glitch.
// Assumes the request is latched on the accepting edge only.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  ctl_state_e        nxt_state,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [LANES-1:0]  lat_be
);

    logic             ce_d, we_d, oe_d, drv_d, act_d;
    logic [LANES-1:0] lane_d;

    // Decode the control strobes for the upcoming phase.
    always_comb begin
        ce_d  = 1'b1;
        we_d  = 1'b1;
        oe_d  = 1'b1;
        drv_d = 1'b0;
        act_d = 1'b0;
        unique case (nxt_state)
            ST_RD: begin
                ce_d  = 1'b0;
                oe_d  = 1'b0;
                act_d = 1'b1;
            end
            ST_WE: begin
                ce_d  = 1'b0;
                we_d  = 1'b0;
                act_d = 1'b1;
            end
            ST_WD: begin
                ce_d  = 1'b0;
                we_d  = 1'b0;
                act_d = 1'b1;
                drv_d = 1'b1;
            end
            ST_WREC: drv_d = 1'b1;
            default: ;
        endcase
    end

    // One strobe per byte lane, low only while active and enabled.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_d[i] = ~(act_d & lat_be[i]);
    end

    // Latch the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            lat_be     <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            lat_be     <= req_be;
        end
    end

    // Register the strobes and the bus drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            lane_n    <= '1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= ce_d;
            mem_we_n  <= we_d;
            mem_oe_n  <= oe_d;
            lane_n    <= lane_d;
            mem_dq_oe <= drv_d;
        end
    end

endmodule

// File: rtl/sram_ctl_rdcap.sv
// Read capture: samples the memory data bus at the end of the last read
// cycle, zeroes disabled lanes and raises a one-cycle valid pulse.
module sram_ctl_rdcap
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_last,
    input  logic [LANES-1:0]  lat_be,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [DATA_W-1:0] masked;

    // Zero each lane whose enable was clear.
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign masked[8*i +: 8] = lat_be[i] ? mem_dq_in[8*i +: 8] : 8'h00;
    end

    // Capture data and generate the response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_last;
            if (rd_last) rsp_rdata <= masked;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
// Top: clocked request port to an asynchronous byte-lane SRAM. Converts
// picosecond limits into cycle counts at elaboration. Assumes the memory
// meets its limits when each phase lasts its rounded-up count of clocks.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W          = 18,
    parameter int CLK_PS          = 5000,
    parameter int T_ADDR_SETUP_PS = 0,
    parameter int T_ADDR_ACC_PS   = 8000,
    parameter int T_OE_ACC_PS     = 4500,
    parameter int T_LANE_ACC_PS   = 4500,
    parameter int T_RD_CYCLE_PS   = 8000,
    parameter int T_WPULSE_PS     = 6500,
    parameter int T_ADDR_WEND_PS  = 6500,
    parameter int T_DSETUP_PS     = 5000,
    parameter int T_WREC_PS       = 0,
    parameter int T_WR_CYCLE_PS   = 8000,
    parameter int TURN_CYC        = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);

    localparam int AS_CYC  = cycles_for(T_ADDR_SETUP_PS, CLK_PS);
    localparam int RD_CYC  = cycles_for(imax(imax(T_ADDR_ACC_PS, T_RD_CYCLE_PS),
                                             imax(T_OE_ACC_PS, T_LANE_ACC_PS)), CLK_PS);
    localparam int WP_CYC  = imax(imax(cycles_for(T_WPULSE_PS, CLK_PS),
                                       cycles_for(T_ADDR_WEND_PS, CLK_PS) - AS_CYC),
                                  1 + cycles_for(T_DSETUP_PS, CLK_PS));
    localparam int WD_CYC  = WP_CYC - 1;
    localparam int REC_CYC = imax(cycles_for(T_WREC_PS, CLK_PS),
                                  cycles_for(T_WR_CYCLE_PS, CLK_PS) - AS_CYC - WP_CYC);
    localparam int MAX_CYC = imax(imax(AS_CYC, RD_CYC),
                                  imax(imax(WP_CYC, REC_CYC), TURN_CYC));
    localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

    ctl_state_e       nxt_state;
    logic             idle, rd_last, accept;
    logic [LANES-1:0] lane_n, lat_be;

    assign req_ready = idle;
    assign accept    = req_valid & idle;
    assign mem_lb_n  = lane_n[0];
    assign mem_ub_n  = lane_n[1];

    sram_ctl_seq #(
        .CNT_W   (CNT_W),
        .AS_CYC  (AS_CYC),
        .RD_CYC  (RD_CYC),
        .WD_CYC  (WD_CYC),
        .REC_CYC (REC_CYC),
        .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .idle     (idle),
        .nxt_state(nxt_state),
        .rd_last  (rd_last)
    );

    sram_ctl_pins #(
        .ADDR_W(ADDR_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .nxt_state (nxt_state),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .lane_n    (lane_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .lat_be    (lat_be)
    );

    sram_ctl_rdcap u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_last  (rd_last),
        .lat_be   (lat_be),
        .mem_dq_in(mem_dq_in),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
// Checker: protocol properties on the controller's ports, bound to the top.
module sram_ctl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);

    logic quiet;
    assign quiet = mem_ce_n & mem_we_n & mem_lb_n & mem_ub_n;

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_addr_moves_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (quiet && $past(quiet)));

    p_read_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_drive_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
// Bench: a transaction-level model predicts ready and responses, and a
// pin-level memory model checks strobe timing and stores written data.
module sram_ctl_tb;

    localparam int PER = 5000;

    function automatic int up(input int ps);
        int c;
        c = (ps + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_AS   = up(0);
    localparam int B_RD   = up(8000);
    localparam int B_WP   = mx(mx(up(6500), up(6500) - B_AS), 1 + up(5000));
    localparam int B_REC  = mx(up(0), up(8000) - B_AS - B_WP);
    localparam int L_WR   = B_AS + B_WP + B_REC;
    localparam int L_RD   = B_AS + B_RD + 1;
    localparam int L_RSP  = B_AS + B_RD;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [17:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hA5A5;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [15:0] shadow [int];
    logic [15:0] pmem   [int];

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        logic [15:0] r;
        r = old;
        if (be[0]) r[7:0]  = nw[7:0];
        if (be[1]) r[15:8] = nw[15:8];
        return r;
    endfunction

    // Transaction model, advanced on each rising edge.
    int          m_rem = 0;
    int          m_rsp_cd = 0;
    bit          m_rsp_v = 0;
    logic [15:0] m_rsp_d = '0;
    logic [15:0] m_pend = '0;
    logic [1:0]  m_be = '0;
    always @(posedge clk) begin
        bit acc;
        logic [15:0] cur;
        if (!rst_n) begin
            m_rem = 0; m_rsp_cd = 0; m_rsp_v = 0;
        end else begin
            acc = req_valid && (m_rem == 0);
            if (m_rem > 0) m_rem--;
            m_rsp_v = 0;
            if (m_rsp_cd > 0) begin
                m_rsp_cd--;
                if (m_rsp_cd == 0) begin m_rsp_v = 1; m_rsp_d = m_pend; end
            end
            if (acc) begin
                m_be = req_be;
                cur  = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 16'h0000;
                if (req_write) begin
                    m_rem = L_WR;
                    shadow[int'(req_addr)] = merge(cur, req_wdata, req_be);
                end else begin
                    m_rem    = L_RD;
                    m_rsp_cd = L_RSP;
                    m_pend   = merge(16'h0000, cur, req_be);
                end
            end
        end
    end

    // Pin-level memory model and port comparison at each falling edge.
    logic [17:0] p_addr = '0;
    bit p_quiet = 1, p_we_n = 1, p_ra = 0, p_lb_n = 1, p_ub_n = 1;
    int addr_age = 0, we_cnt = 0, drv_cnt = 0, rd_cnt = 0;
    logic [15:0] w_data = '0;
    always @(negedge clk) begin
        bit quiet, ra;
        logic [15:0] cur;
        if (rst_n && !done) begin
            check(req_ready === (m_rem == 0), "R2 req_ready", req_ready, m_rem == 0);
            check(rsp_valid === m_rsp_v, "R5 rsp_valid", rsp_valid, m_rsp_v);
            if (m_rsp_v) check(rsp_rdata === m_rsp_d, "R5 rsp_rdata", rsp_rdata, m_rsp_d);

            quiet = mem_ce_n & mem_we_n & mem_lb_n & mem_ub_n;
            if (mem_addr !== p_addr) begin
                check(p_quiet && quiet, "R3 address moved under strobe", {p_quiet, quiet}, 2'b11);
                addr_age = 0;
            end else addr_age++;
            if (!quiet && p_quiet)
                check(addr_age >= B_AS, "R3 address setup", addr_age, B_AS);
            if (mem_dq_oe) check(mem_oe_n === 1'b1, "R7 drive while oe low", mem_oe_n, 1);

            // Write-enable pulse tracking.
            if (!mem_we_n) begin
                check(mem_oe_n === 1'b1, "R6 oe during write", mem_oe_n, 1);
                check(!mem_ce_n && ({mem_ub_n, mem_lb_n} === ~m_be), "R6 write strobes",
                      {mem_ce_n, mem_ub_n, mem_lb_n}, {1'b0, ~m_be});
                if (p_we_n) check(mem_dq_oe === 1'b0, "R7 first cycle undriven", mem_dq_oe, 0);
                we_cnt++;
                if (mem_dq_oe) begin drv_cnt++; w_data = mem_dq_out; end
            end else if (!p_we_n) begin
                check(we_cnt == B_WP, "R6 pulse length", we_cnt, B_WP);
                check(drv_cnt == B_WP - 1, "R7 drive window", drv_cnt, B_WP - 1);
                check(mem_dq_oe === 1'b1, "R7 hold after pulse", mem_dq_oe, 1);
                cur = pmem.exists(int'(p_addr)) ? pmem[int'(p_addr)] : 16'h0000;
                pmem[int'(p_addr)] = merge(cur, w_data, {~p_ub_n, ~p_lb_n});
                we_cnt = 0; drv_cnt = 0;
            end

            // Read tracking and bus model.
            ra = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (ra) begin
                check(({mem_ub_n, mem_lb_n} === ~m_be) && !mem_dq_oe, "R4 read strobes",
                      {mem_dq_oe, mem_ub_n, mem_lb_n}, {1'b0, ~m_be});
                rd_cnt++;
            end else if (p_ra) begin
                check(rd_cnt == B_RD, "R4 read length", rd_cnt, B_RD);
                check(quiet && !mem_dq_oe, "R9 turnaround quiet", {quiet, mem_dq_oe}, 2'b10);
                rd_cnt = 0;
            end
            mem_dq_in = 16'hA5A5;
            if (ra && rd_cnt >= B_RD) begin
                cur = pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 16'h0000;
                if (!mem_lb_n) mem_dq_in[7:0]  = cur[7:0];
                if (!mem_ub_n) mem_dq_in[15:8] = cur[15:8];
            end

            p_addr = mem_addr; p_quiet = quiet; p_we_n = mem_we_n; p_ra = ra;
            p_lb_n = mem_lb_n; p_ub_n = mem_ub_n;
        end
    end

    // Present one request and hold it until it is taken.
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        bit got;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        do begin
            got = req_ready;
            @(negedge clk);
        end while (!got);
    endtask

    task automatic settle();
        req_valid = 0;
        do @(negedge clk); while (!req_ready);
        repeat (2) @(negedge clk);
    endtask

    task automatic reset_outputs(input string tag);
        check(req_ready === 1'b1 && rsp_valid === 1'b0, {tag, " handshake"},
              {req_ready, rsp_valid}, 2'b10);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe} === 6'b111110,
              {tag, " pins"}, {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              6'b111110);
    endtask

    initial begin
        logic [31:0] lfsr;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        reset_outputs("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        reset_outputs("R1 after reset");

        // R6 R4 R5: full-word write and read, low and top addresses.
        do_req(1, 18'h00010, 16'h1234, 2'b11); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b11); settle();
        do_req(1, 18'h3FFFF, 16'hBEEF, 2'b11); settle();
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11); settle();
        // R8: single-lane writes leave the other lane alone.
        do_req(1, 18'h00010, 16'hAAFF, 2'b01); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b11); settle();
        do_req(1, 18'h00010, 16'h55EE, 2'b10); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b11); settle();
        // R5: disabled lanes read back as zero.
        do_req(0, 18'h00010, 16'h0000, 2'b01); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b10); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b00); settle();
        // R8: write with no lanes enabled changes nothing.
        do_req(1, 18'h00010, 16'h0000, 2'b00); settle();
        do_req(0, 18'h00010, 16'h0000, 2'b11); settle();
        // R2 R9: back-to-back requests held while busy, read then write.
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_req(1, 18'h00011, 16'hC0DE, 2'b11);
        do_req(0, 18'h00011, 16'h0000, 2'b11);
        do_req(0, 18'h00010, 16'h0000, 2'b11);
        settle();
        // Mixed traffic from a fixed LFSR.
        lfsr = 32'h1D872B41;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_req(lfsr[0], {lfsr[9] ? 15'h7FFF : 15'h0000, lfsr[3:1]}, lfsr[31:16], lfsr[5:4]);
            if (lfsr[6]) settle();
        end
        settle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=idle");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule